// File: doc/BRIEF.md
# Transmit Line Overhead Byte Inserter

This block is on the transmit side of a SONET/SDH framer. It takes a stream of bytes, one per cycle when `slot_vld` is high. Each byte comes with a slot tag, and the block writes the contents of the tagged overhead slots. The byte placed in the synchronization-status slot comes from one of two sources: a software register or an external overhead access port. The two protection-switching bytes are built from provisioned values. When a line alarm has to be signalled, the alarm overrides the low three bits of the second protection byte. A test mode changes the first protection byte on every frame, so that a far end sees inconsistent switching requests.

The block also produces the line remote-defect indication. It ORs six receive-side defect flags, and each flag has its own inhibit bit. A bypass setting stops every overhead write, so the stream passes through unchanged for packet-over-fibre use. All provisioning and defect inputs are latched on the frame-start strobe, so one frame never mixes old and new settings.

Top module: `tx_toh_inserter`

## Requirements
- R1: `out_vld` and `out_byte` are registered one cycle after `slot_vld`. When `out_vld` is low, `out_byte` is 0x00. After reset, `out_vld`, `out_byte` and `rdi_line` are all 0.
- R2: A slot tagged `slot_id` = 0 (ordinary byte) leaves the block as `in_byte` unchanged.
- R3: A slot tagged `slot_id` = 1 (sync status) carries `cfg_s1_value` when `cfg_s1_from_reg` = 1. The software register wins over the access port. When `cfg_s1_from_reg` = 0, the slot carries `toac_byte`.
- R4: A slot tagged `slot_id` = 2 (first protection byte) carries `cfg_k1` when babble mode is off.
- R5: A slot tagged `slot_id` = 3 (second protection byte) carries `cfg_k2[7:3]` in its upper five bits. Its low three bits are 3'b111 when `line_ais_send` = 1. Otherwise they are 3'b110 when line RDI is active. Otherwise they are `cfg_k2[2:0]`.
- R6: `rdi_line` is the OR of `rx_defects[i] & ~cfg_rdi_inhibit[i]`, with bit order 0 LOF, 1 OOF, 2 LOS, 3 LOC, 4 line AIS, 5 signal fail. It changes only on the cycle after a frame start.
- R7: A set inhibit bit removes its defect from `rdi_line` and from the K2 RDI code, even while that defect is active.
- R8: With `cfg_babble` = 1, the first protection byte is (`cfg_k1` + N) mod 256. N is the number of frame-start pulses since reset, including the current frame, so each frame differs from the one before.
- R9: With `cfg_bypass` = 1, every slot carries `in_byte`, whatever its tag.
- R10: All `cfg_*`, `line_ais_send` and `rx_defects` values are captured on the `frame_start` cycle and hold until the next frame start. A slot presented on the `frame_start` cycle itself already uses the newly captured values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse that opens a frame and captures provisioning |
| slot_vld | input | 1 | A byte is present this cycle |
| slot_id | input | 2 | Slot tag: 0 ordinary, 1 sync status, 2 first protection, 3 second protection |
| in_byte | input | 8 | Byte from the outgoing stream |
| toac_byte | input | 8 | Byte from the external overhead access port |
| cfg_bypass | input | 1 | Disable all overhead writes |
| cfg_s1_from_reg | input | 1 | Take the sync-status byte from the register |
| cfg_s1_value | input | 8 | Software sync-status value |
| cfg_k1 | input | 8 | Provisioned first protection byte |
| cfg_k2 | input | 8 | Provisioned second protection byte |
| cfg_babble | input | 1 | Make the first protection byte change every frame |
| line_ais_send | input | 1 | Line AIS is to be signalled |
| rx_defects | input | 6 | Receive defects: LOF, OOF, LOS, LOC, AIS-L, SF (bit 0 first) |
| cfg_rdi_inhibit | input | 6 | Per-defect inhibit, same bit order |
| out_vld | output | 1 | Output byte valid |
| out_byte | output | 8 | Byte to transmit |
| rdi_line | output | 1 | Line remote-defect indication |

## Verification
Several properties are checked on every cycle: the one-cycle latency of the valid flag, pass-through of ordinary and bypassed bytes, the register value winning in the sync-status slot, the all-ones alarm code under line AIS, and `rdi_line` holding steady between frame starts. Other behaviour needs scenarios in the bench: each defect is raised with and without its inhibit, babble frames are counted, provisioning changes in the middle of a frame, and a slot is presented on the frame-start cycle itself. The bench's own reference model compares every output on every cycle.

// File: rtl/tx_toh_pkg.sv
package tx_toh_pkg;
  localparam int BYTE_W  = 8;
  localparam int NUM_DEF = 6;
  localparam int SLOT_W  = 2;
  localparam int CODE_W  = 3;

  typedef enum logic [SLOT_W-1:0] {
    SLOT_PLAIN = 2'd0,
    SLOT_SYNC  = 2'd1,
    SLOT_APS1  = 2'd2,
    SLOT_APS2  = 2'd3
  } slot_e;

  typedef struct packed {
    logic               bypass;
    logic               s1_from_reg;
    logic [BYTE_W-1:0]  s1_value;
    logic [BYTE_W-1:0]  k1;
    logic [BYTE_W-1:0]  k2;
    logic               babble;
    logic               ais_send;
    logic [NUM_DEF-1:0] defects;
    logic [NUM_DEF-1:0] inhibit;
  } prov_t;

  localparam logic [CODE_W-1:0] CODE_AIS = 3'b111;
  localparam logic [CODE_W-1:0] CODE_RDI = 3'b110;

  function automatic logic [BYTE_W-1:0] aps2_build(input logic [BYTE_W-1:0] k2,
                                                   input logic ais, input logic rdi);
    logic [CODE_W-1:0] code;
    code = ais ? CODE_AIS : (rdi ? CODE_RDI : k2[CODE_W-1:0]);
    return {k2[BYTE_W-1:CODE_W], code};
  endfunction

  function automatic logic [BYTE_W-1:0] aps1_build(input logic [BYTE_W-1:0] k1,
                                                   input logic babble,
                                                   input logic [BYTE_W-1:0] frame_idx);
    return babble ? k1 + frame_idx : k1;
  endfunction
endpackage

// File: rtl/toh_prov_shadow.sv
module toh_prov_shadow
  import tx_toh_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  input  prov_t              live,
  output prov_t              eff,
  output logic [BYTE_W-1:0]  frame_idx_eff,
  output logic [NUM_DEF-1:0] held_defects,
  output logic [NUM_DEF-1:0] held_inhibit
);
  prov_t             held_q;
  logic [BYTE_W-1:0] frame_idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q      <= '0;
      frame_idx_q <= '0;
    end else if (frame_start) begin
      held_q      <= live;
      frame_idx_q <= frame_idx_q + 1'b1;
    end
  end

  // the frame-start cycle already sees the values being captured
  assign eff           = frame_start ? live : held_q;
  assign frame_idx_eff = frame_start ? frame_idx_q + 1'b1 : frame_idx_q;
  assign held_defects  = held_q.defects;
  assign held_inhibit  = held_q.inhibit;
endmodule

// File: rtl/toh_rdi_fold.sv
module toh_rdi_fold
  import tx_toh_pkg::*;
(
  input  logic [NUM_DEF-1:0] defects,
  input  logic [NUM_DEF-1:0] inhibit,
  output logic               rdi
);
  logic [NUM_DEF-1:0] live_contrib;

  for (genvar i = 0; i < NUM_DEF; i++) begin : g_def
    assign live_contrib[i] = defects[i] & ~inhibit[i];
  end

  assign rdi = |live_contrib;
endmodule

// File: rtl/toh_byte_mux.sv
module toh_byte_mux
  import tx_toh_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_vld,
  input  logic [SLOT_W-1:0] slot_id,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic [BYTE_W-1:0] toac_byte,
  input  logic              bypass,
  input  logic              s1_from_reg,
  input  logic [BYTE_W-1:0] s1_value,
  input  logic [BYTE_W-1:0] k1,
  input  logic [BYTE_W-1:0] k2,
  input  logic              babble,
  input  logic              ais_send,
  input  logic              rdi,
  input  logic [BYTE_W-1:0] frame_idx,
  output logic              out_vld,
  output logic [BYTE_W-1:0] out_byte
);
  logic [BYTE_W-1:0] pick;

  always_comb begin
    unique case (slot_e'(slot_id))
      SLOT_SYNC: pick = s1_from_reg ? s1_value : toac_byte;
      SLOT_APS1: pick = aps1_build(k1, babble, frame_idx);
      SLOT_APS2: pick = aps2_build(k2, ais_send, rdi);
      default:   pick = in_byte;
    endcase
    if (bypass) pick = in_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_byte <= '0;
    end else begin
      out_vld  <= slot_vld;
      out_byte <= slot_vld ? pick : '0;
    end
  end
endmodule

// File: rtl/tx_toh_inserter.sv
module tx_toh_inserter
  import tx_toh_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  input  logic               slot_vld,
  input  logic [SLOT_W-1:0]  slot_id,
  input  logic [BYTE_W-1:0]  in_byte,
  input  logic [BYTE_W-1:0]  toac_byte,
  input  logic               cfg_bypass,
  input  logic               cfg_s1_from_reg,
  input  logic [BYTE_W-1:0]  cfg_s1_value,
  input  logic [BYTE_W-1:0]  cfg_k1,
  input  logic [BYTE_W-1:0]  cfg_k2,
  input  logic               cfg_babble,
  input  logic               line_ais_send,
  input  logic [NUM_DEF-1:0] rx_defects,
  input  logic [NUM_DEF-1:0] cfg_rdi_inhibit,
  output logic               out_vld,
  output logic [BYTE_W-1:0]  out_byte,
  output logic               rdi_line
);
  prov_t              live;
  prov_t              eff;
  logic [BYTE_W-1:0]  frame_idx;
  logic [NUM_DEF-1:0] held_defects;
  logic [NUM_DEF-1:0] held_inhibit;
  logic               eff_rdi;

  // named internal events, also observed by the checker
  logic               eff_bypass;
  logic               eff_s1_sel;
  logic [BYTE_W-1:0]  eff_s1_val;
  logic               eff_ais;

  always_comb begin
    live.bypass      = cfg_bypass;
    live.s1_from_reg = cfg_s1_from_reg;
    live.s1_value    = cfg_s1_value;
    live.k1          = cfg_k1;
    live.k2          = cfg_k2;
    live.babble      = cfg_babble;
    live.ais_send    = line_ais_send;
    live.defects     = rx_defects;
    live.inhibit     = cfg_rdi_inhibit;
  end

  toh_prov_shadow u_shadow (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_start   (frame_start),
    .live          (live),
    .eff           (eff),
    .frame_idx_eff (frame_idx),
    .held_defects  (held_defects),
    .held_inhibit  (held_inhibit)
  );

  assign eff_bypass = eff.bypass;
  assign eff_s1_sel = eff.s1_from_reg;
  assign eff_s1_val = eff.s1_value;
  assign eff_ais    = eff.ais_send;

  toh_rdi_fold u_rdi_eff (
    .defects (eff.defects),
    .inhibit (eff.inhibit),
    .rdi     (eff_rdi)
  );

  toh_rdi_fold u_rdi_held (
    .defects (held_defects),
    .inhibit (held_inhibit),
    .rdi     (rdi_line)
  );

  toh_byte_mux u_mux (
    .clk         (clk),
    .rst_n       (rst_n),
    .slot_vld    (slot_vld),
    .slot_id     (slot_id),
    .in_byte     (in_byte),
    .toac_byte   (toac_byte),
    .bypass      (eff_bypass),
    .s1_from_reg (eff_s1_sel),
    .s1_value    (eff_s1_val),
    .k1          (eff.k1),
    .k2          (eff.k2),
    .babble      (eff.babble),
    .ais_send    (eff_ais),
    .rdi         (eff_rdi),
    .frame_idx   (frame_idx),
    .out_vld     (out_vld),
    .out_byte    (out_byte)
  );
endmodule

// File: rtl/toh_inserter_chk.sv
module toh_inserter_chk
  import tx_toh_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               frame_start,
  input logic               slot_vld,
  input logic [SLOT_W-1:0]  slot_id,
  input logic [BYTE_W-1:0]  in_byte,
  input logic [NUM_DEF-1:0] rx_defects,
  input logic [NUM_DEF-1:0] cfg_rdi_inhibit,
  input logic               out_vld,
  input logic [BYTE_W-1:0]  out_byte,
  input logic               rdi_line,
  input logic               eff_bypass,
  input logic               eff_s1_sel,
  input logic [BYTE_W-1:0]  eff_s1_val,
  input logic               eff_ais
);
  assert_vld_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    slot_vld |=> out_vld);
  assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_vld |=> (!out_vld && out_byte == '0));
  assert_plain_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_vld && slot_id == SLOT_PLAIN) |=> out_byte == $past(in_byte));
  assert_sync_reg_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_vld && slot_id == SLOT_SYNC && eff_s1_sel && !eff_bypass)
      |=> out_byte == $past(eff_s1_val));
  assert_ais_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_vld && slot_id == SLOT_APS2 && eff_ais && !eff_bypass)
      |=> out_byte[CODE_W-1:0] == CODE_AIS);
  assert_rdi_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(rdi_line));
  assert_rdi_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> rdi_line == ($countones($past(rx_defects) & ~$past(cfg_rdi_inhibit)) != 0));
  assert_bypass_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_vld && eff_bypass) |=> out_byte == $past(in_byte));
endmodule

bind tx_toh_inserter toh_inserter_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .frame_start     (frame_start),
  .slot_vld        (slot_vld),
  .slot_id         (slot_id),
  .in_byte         (in_byte),
  .rx_defects      (rx_defects),
  .cfg_rdi_inhibit (cfg_rdi_inhibit),
  .out_vld         (out_vld),
  .out_byte        (out_byte),
  .rdi_line        (rdi_line),
  .eff_bypass      (eff_bypass),
  .eff_s1_sel      (eff_s1_sel),
  .eff_s1_val      (eff_s1_val),
  .eff_ais         (eff_ais)
);

// File: tb/tb_tx_toh_inserter.sv
`timescale 1ns/1ps
module tb_tx_toh_inserter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_start = 1'b0;
  logic       slot_vld = 1'b0;
  logic [1:0] slot_id = 2'd0;
  logic [7:0] in_byte = 8'h00;
  logic [7:0] toac_byte = 8'h00;
  logic       cfg_bypass = 1'b0;
  logic       cfg_s1_from_reg = 1'b0;
  logic [7:0] cfg_s1_value = 8'h00;
  logic [7:0] cfg_k1 = 8'h00;
  logic [7:0] cfg_k2 = 8'h00;
  logic       cfg_babble = 1'b0;
  logic       line_ais_send = 1'b0;
  logic [5:0] rx_defects = 6'd0;
  logic [5:0] cfg_rdi_inhibit = 6'd0;
  logic       out_vld;
  logic [7:0] out_byte;
  logic       rdi_line;

  always #2 clk = ~clk;

  tx_toh_inserter dut (.*);

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done = 1'b0;
  string scen = "R1";
  logic [31:0] seed = 32'h1234_5678;

  // reference model state: plain integers, frame-latched copies
  int m_byp, m_sel, m_sval, m_k1, m_k2, m_bab, m_ais, m_def, m_inh, m_frames;
  int e_vld, e_byte, e_rdi;
  string tag;

  function automatic int rdi_of(int def, int inh);
    int any = 0;
    for (int i = 0; i < 6; i++)
      if (((def >> i) & 1) == 1 && ((inh >> i) & 1) == 0) any = 1;
    return any;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_byp = 0; m_sel = 0; m_sval = 0; m_k1 = 0; m_k2 = 0; m_bab = 0;
      m_ais = 0; m_def = 0; m_inh = 0; m_frames = 0;
      e_vld = 0; e_byte = 0; e_rdi = 0; tag = "R1";
    end else begin
      if (frame_start) begin
        m_byp = cfg_bypass; m_sel = cfg_s1_from_reg; m_sval = cfg_s1_value;
        m_k1 = cfg_k1; m_k2 = cfg_k2; m_bab = cfg_babble; m_ais = line_ais_send;
        m_def = rx_defects; m_inh = cfg_rdi_inhibit;
        m_frames = m_frames + 1;
      end
      e_vld = slot_vld; e_byte = 0; tag = "R1";
      if (slot_vld) begin
        if (m_byp != 0) begin e_byte = in_byte; tag = "R9"; end
        else case (slot_id)
          2'd1: begin e_byte = (m_sel != 0) ? m_sval : toac_byte; tag = "R3"; end
          2'd2: begin
            e_byte = (m_bab != 0) ? (m_k1 + m_frames) % 256 : m_k1;
            tag = (m_bab != 0) ? "R8" : "R4";
          end
          2'd3: begin
            int low;
            low = (m_ais != 0) ? 7 : ((rdi_of(m_def, m_inh) != 0) ? 6 : m_k2 % 8);
            e_byte = (m_k2 / 8) * 8 + low; tag = "R5";
          end
          default: begin e_byte = in_byte; tag = "R2"; end
        endcase
      end
      e_rdi = rdi_of(m_def, m_inh);
    end
    #1;
    n_cmp++;
    if (out_vld !== e_vld[0] || out_byte !== e_byte[7:0]) begin
      n_bad++;
      $display("FAIL %s/%s: vld=%0b byte=%02h expected vld=%0d byte=%02h",
               tag, scen, out_vld, out_byte, e_vld, e_byte);
    end
    n_cmp++;
    if (rdi_line !== e_rdi[0]) begin
      n_bad++;
      $display("FAIL R6/%s: rdi_line=%0b expected %0d", scen, rdi_line, e_rdi);
    end
  end

  function automatic logic [7:0] nxt();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed[7:0];
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic put_slot(input logic [1:0] id);
    slot_vld = 1'b1; slot_id = id; in_byte = nxt(); toac_byte = nxt();
    tick();
    slot_vld = 1'b0;
  endtask

  task automatic open_frame();
    frame_start = 1'b1; tick(); frame_start = 1'b0;
  endtask

  task automatic full_frame();
    open_frame();
    put_slot(2'd1); put_slot(2'd2); put_slot(2'd3);
    put_slot(2'd0); put_slot(2'd0);
    tick();
  endtask

  initial begin
    tick(); tick(); tick();
    rst_n = 1'b1;
    tick();

    scen = "R2"; cfg_k1 = 8'h5A; cfg_k2 = 8'hA5; full_frame();
    scen = "R3"; cfg_s1_from_reg = 1'b1; cfg_s1_value = 8'h0F; full_frame();
    scen = "R4"; cfg_s1_from_reg = 1'b0; cfg_k1 = 8'h3C; cfg_k2 = 8'h41; full_frame();

    for (int d = 0; d < 6; d++) begin
      scen = "R6"; rx_defects = 6'(1 << d); cfg_rdi_inhibit = 6'd0; full_frame();
      scen = "R7"; cfg_rdi_inhibit = 6'(1 << d); full_frame();
      cfg_rdi_inhibit = 6'h3F ^ 6'(1 << d); full_frame();
    end
    rx_defects = 6'd0; cfg_rdi_inhibit = 6'd0; full_frame();

    scen = "R5"; line_ais_send = 1'b1; full_frame();
    rx_defects = 6'h21; full_frame();
    line_ais_send = 1'b0; rx_defects = 6'd0; full_frame();

    scen = "R8"; cfg_babble = 1'b1; cfg_k1 = 8'hFE;
    for (int f = 0; f < 5; f++) full_frame();
    cfg_babble = 1'b0; full_frame();

    scen = "R10"; open_frame();
    cfg_k1 = 8'h77; cfg_s1_from_reg = 1'b1; cfg_s1_value = 8'hC3; rx_defects = 6'h04;
    put_slot(2'd2); put_slot(2'd1); put_slot(2'd3); tick();
    full_frame();
    cfg_k1 = 8'h99;
    frame_start = 1'b1; put_slot(2'd2); frame_start = 1'b0;
    put_slot(2'd2); tick();
    rx_defects = 6'd0; full_frame();

    scen = "R9"; cfg_bypass = 1'b1; line_ais_send = 1'b1; full_frame();
    cfg_bypass = 1'b0; line_ais_send = 1'b0; full_frame();

    scen = "R1"; rst_n = 1'b0; tick(); tick(); rst_n = 1'b1; tick(); tick();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule